// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Sequential Arithmetic Unit

This block is a multi-cycle arithmetic unit for 32-bit sign-magnitude words. Bit 31 is the sign (1 = negative). Bits 30:0 are an unsigned fixed-point magnitude with 15 integer bits and 16 fraction bits, so magnitude bit 16 has weight 1.0. Two operand registers sit next to the datapath. The accumulator holds operand A and receives every result. The second register holds operand B, and no operation changes it.

A host fills the two registers through a simple load strobe. It then pulses `start_i` with a 2-bit opcode. Add and subtract finish on the next clock edge. Multiply runs a shift-and-add loop that handles one multiplier bit per cycle. Divide runs a restoring loop that spends two cycles on each quotient bit. Completion is marked by a one-cycle `done_o` pulse, together with sticky-until-next-result flags for overflow and divide-by-zero.

Top module: `smfx_alu`

## Requirements
- R1: After reset, the accumulator, operand B, `busy_o`, `done_o`, `ovf_o` and `dz_o` are all zero.
- R2: When idle and `start_i` is low, a pulse on `ld_en_i` writes `ld_data_i` into the accumulator if `ld_sel_i`=0, or into operand B if `ld_sel_i`=1. Bit 31 is the sign, and bits 30:0 are the magnitude with the binary point between bits 16 and 15.
- R3: Opcode 00 computes A+B and opcode 01 computes A−B, both in sign-magnitude. When the effective signs differ, the smaller magnitude is subtracted from the larger and the sign of the larger is kept. Done rises on the first edge after the accepting edge.
- R4: Opcode 10 gives magnitude floor(|A|·|B| / 2^16) and sign A31 XOR B31. Done rises 31 edges after the accepting edge.
- R5: Opcode 11 with nonzero |B| gives magnitude floor(|A|·2^16 / |B|) and sign A31 XOR B31. Done rises 94 edges after the accepting edge.
- R6: If a result magnitude does not fit in 31 bits, the magnitude becomes 0x7FFFFFFF and `ovf_o` is set. Otherwise `ovf_o` is cleared. The flag changes only when an operation completes.
- R7: Opcode 11 with |B|=0 writes A's sign with magnitude 0x7FFFFFFF, sets `dz_o`, clears `ovf_o`, and raises done on the first edge after acceptance. `dz_o` is cleared by any other completion.
- R8: A result with zero magnitude is always written with sign 0.
- R9: `done_o` is high for exactly one cycle. `busy_o` is high from the accepting edge until done rises. A `start_i` that arrives while busy is ignored.
- R10: Loads are ignored while busy, and also in any cycle where `start_i` is high. Operand B is never changed by an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin operation (sampled when idle) |
| op_i | input | 2 | Opcode: 00 add, 01 sub, 10 mul, 11 div |
| ld_en_i | input | 1 | Operand load strobe |
| ld_sel_i | input | 1 | Load target: 0 accumulator, 1 operand B |
| ld_data_i | input | 32 | Load value |
| acc_o | output | 32 | Accumulator (operand A / result) |
| opb_o | output | 32 | Operand B |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Last result saturated |
| dz_o | output | 1 | Last result was a divide by zero |

## Verification
The assertions assume `start_i` and `ld_en_i` are synchronous and only meaningful as single-cycle requests. They do not assume the host avoids asserting them while busy. The stimulus deliberately asserts both during a multiply and alongside a start, so the ignore rules are exercised. Inputs change one time unit after a rising edge. A behavioural model built on 64-bit integer arithmetic predicts every port on every cycle, using random magnitudes across several ranges and signs that include zero and saturating cases.

// File: rtl/smfx_pkg.sv
package smfx_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } smfx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FAST,
        ST_MUL,
        ST_DIV
    } smfx_st_e;
endpackage

// File: rtl/smfx_addsub.sv
module smfx_addsub #(
    parameter int MAG_W = 31
) (
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    input  logic             subtract,
    output logic             r_sign,
    output logic [MAG_W-1:0] r_mag,
    output logic             r_ovf
);
    logic           eff_b;
    logic [MAG_W:0] sum;

    always_comb begin
        eff_b  = b_sign ^ subtract;
        sum    = '0;
        r_ovf  = 1'b0;
        if (a_sign == eff_b) begin
            sum    = {1'b0, a_mag} + {1'b0, b_mag};
            r_ovf  = sum[MAG_W];
            r_mag  = sum[MAG_W] ? '1 : sum[MAG_W-1:0];
            r_sign = a_sign;
        end else if (a_mag >= b_mag) begin
            r_mag  = a_mag - b_mag;
            r_sign = a_sign;
        end else begin
            r_mag  = b_mag - a_mag;
            r_sign = eff_b;
        end
        if (r_mag == '0) r_sign = 1'b0;
    end
endmodule

// File: rtl/smfx_mul_step.sv
module smfx_mul_step #(
    parameter int MAG_W = 31,
    parameter int PW    = 2 * MAG_W
) (
    input  logic [PW-1:0]    mcand,
    input  logic [MAG_W-1:0] mplier,
    input  logic [PW-1:0]    prod,
    output logic [PW-1:0]    mcand_n,
    output logic [MAG_W-1:0] mplier_n,
    output logic [PW-1:0]    prod_n
);
    always_comb begin
        prod_n   = mplier[0] ? prod + mcand : prod;
        mcand_n  = mcand << 1;
        mplier_n = mplier >> 1;
    end
endmodule

// File: rtl/smfx_div_step.sv
module smfx_div_step #(
    parameter int MAG_W = 31,
    parameter int QW    = 47
) (
    input  logic             restore,
    input  logic [MAG_W+1:0] rem,
    input  logic [QW-1:0]    dvd,
    input  logic [QW-1:0]    quo,
    input  logic [MAG_W-1:0] divisor,
    output logic [MAG_W+1:0] rem_n,
    output logic [QW-1:0]    dvd_n,
    output logic [QW-1:0]    quo_n
);
    logic [MAG_W:0] shifted;

    always_comb begin
        shifted = {rem[MAG_W-1:0], dvd[QW-1]};
        rem_n   = rem;
        dvd_n   = dvd;
        quo_n   = quo;
        if (!restore) begin
            rem_n = {1'b0, shifted} - {2'b00, divisor};
            dvd_n = dvd << 1;
        end else if (rem[MAG_W+1]) begin
            rem_n = rem + {2'b00, divisor};
            quo_n = {quo[QW-2:0], 1'b0};
        end else begin
            quo_n = {quo[QW-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/smfx_alu.sv
module smfx_alu
    import smfx_pkg::*;
#(
    parameter int MAG_W  = 31,
    parameter int FRAC_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic                ld_en_i,
    input  logic                ld_sel_i,
    input  logic [MAG_W:0]      ld_data_i,
    output logic [MAG_W:0]      acc_o,
    output logic [MAG_W:0]      opb_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                ovf_o,
    output logic                dz_o
);
    localparam int W       = MAG_W + 1;
    localparam int PW      = 2 * MAG_W;
    localparam int QW      = MAG_W + FRAC_W;
    localparam int DIV_CYC = 2 * QW;
    localparam int CW      = $clog2(DIV_CYC + 1);

    typedef struct packed {
        smfx_st_e         st;
        smfx_op_e         op;
        logic [CW-1:0]    cnt;
        logic [W-1:0]     acc;
        logic [W-1:0]     opb;
        logic             rsign;
        logic             done;
        logic             ovf;
        logic             dz;
        logic [PW-1:0]    prod;
        logic [PW-1:0]    mcand;
        logic [MAG_W-1:0] mplier;
        logic [MAG_W+1:0] rem;
        logic [QW-1:0]    dvd;
        logic [QW-1:0]    quo;
    } smfx_state_t;

    smfx_state_t s_q, s_d;

    logic             as_sign, as_ovf;
    logic [MAG_W-1:0] as_mag;
    logic [PW-1:0]    mcand_n, prod_n, prod_sh;
    logic [MAG_W-1:0] mplier_n;
    logic [MAG_W+1:0] rem_n;
    logic [QW-1:0]    dvd_n, quo_n;

    smfx_addsub #(.MAG_W(MAG_W)) u_addsub (
        .a_sign  (s_q.acc[W-1]),
        .a_mag   (s_q.acc[MAG_W-1:0]),
        .b_sign  (s_q.opb[W-1]),
        .b_mag   (s_q.opb[MAG_W-1:0]),
        .subtract(s_q.op == OP_SUB),
        .r_sign  (as_sign),
        .r_mag   (as_mag),
        .r_ovf   (as_ovf)
    );

    smfx_mul_step #(.MAG_W(MAG_W), .PW(PW)) u_mul (
        .mcand   (s_q.mcand),
        .mplier  (s_q.mplier),
        .prod    (s_q.prod),
        .mcand_n (mcand_n),
        .mplier_n(mplier_n),
        .prod_n  (prod_n)
    );

    smfx_div_step #(.MAG_W(MAG_W), .QW(QW)) u_div (
        .restore (s_q.cnt[0]),
        .rem     (s_q.rem),
        .dvd     (s_q.dvd),
        .quo     (s_q.quo),
        .divisor (s_q.opb[MAG_W-1:0]),
        .rem_n   (rem_n),
        .dvd_n   (dvd_n),
        .quo_n   (quo_n)
    );

    assign prod_sh = prod_n >> FRAC_W;

    always_comb begin
        logic             fin;
        logic             f_ovf;
        logic [MAG_W-1:0] f_mag;
        s_d      = s_q;
        s_d.done = 1'b0;
        fin      = 1'b0;
        f_ovf    = 1'b0;
        f_mag    = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.op    = smfx_op_e'(op_i);
                    s_d.cnt   = '0;
                    s_d.rsign = s_q.acc[W-1] ^ s_q.opb[W-1];
                    s_d.st    = ST_FAST;
                    if (op_i == OP_MUL) begin
                        s_d.st     = ST_MUL;
                        s_d.mcand  = {{(PW-MAG_W){1'b0}}, s_q.acc[MAG_W-1:0]};
                        s_d.mplier = s_q.opb[MAG_W-1:0];
                        s_d.prod   = '0;
                    end else if (op_i == OP_DIV && s_q.opb[MAG_W-1:0] != '0) begin
                        s_d.st  = ST_DIV;
                        s_d.rem = '0;
                        s_d.dvd = {s_q.acc[MAG_W-1:0], {FRAC_W{1'b0}}};
                        s_d.quo = '0;
                    end
                end else if (ld_en_i) begin
                    if (ld_sel_i) s_d.opb = ld_data_i;
                    else          s_d.acc = ld_data_i;
                end
            end
            ST_FAST: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
                if (s_q.op == OP_DIV) begin
                    s_d.acc = {s_q.acc[W-1], {MAG_W{1'b1}}};
                    s_d.ovf = 1'b0;
                    s_d.dz  = 1'b1;
                end else begin
                    s_d.acc = {as_sign, as_mag};
                    s_d.ovf = as_ovf;
                    s_d.dz  = 1'b0;
                end
            end
            ST_MUL: begin
                s_d.mcand  = mcand_n;
                s_d.mplier = mplier_n;
                s_d.prod   = prod_n;
                s_d.cnt    = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(MAG_W - 1)) begin
                    fin   = 1'b1;
                    f_ovf = |prod_sh[PW-1:MAG_W];
                    f_mag = prod_sh[MAG_W-1:0];
                end
            end
            default: begin
                s_d.rem = rem_n;
                s_d.dvd = dvd_n;
                s_d.quo = quo_n;
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(DIV_CYC - 1)) begin
                    fin   = 1'b1;
                    f_ovf = |quo_n[QW-1:MAG_W];
                    f_mag = quo_n[MAG_W-1:0];
                end
            end
        endcase
        if (fin) begin
            if (f_ovf) f_mag = '1;
            s_d.acc  = {(f_mag != '0) & s_q.rsign, f_mag};
            s_d.ovf  = f_ovf;
            s_d.dz   = 1'b0;
            s_d.done = 1'b1;
            s_d.st   = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.op  <= OP_ADD;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_o  = s_q.acc;
    assign opb_o  = s_q.opb;
    assign busy_o = (s_q.st != ST_IDLE);
    assign done_o = s_q.done;
    assign ovf_o  = s_q.ovf;
    assign dz_o   = s_q.dz;

    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R8
    zero_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && acc_o[MAG_W-1:0] == '0) |-> !acc_o[W-1]);
    // R6
    sat_on_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && ovf_o) |-> (&acc_o[MAG_W-1:0]));
    // R7
    dz_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && dz_o) |-> ((&acc_o[MAG_W-1:0]) && !ovf_o));
    // R10
    opb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(opb_o));
    // R9
    busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/smfx_alu_tb_top.sv
module smfx_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] acc_o, opb_o;
    logic        busy_o, done_o, ovf_o, dz_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smfx_alu dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
        .acc_o(acc_o), .opb_o(opb_o), .busy_o(busy_o), .done_o(done_o),
        .ovf_o(ovf_o), .dz_o(dz_o)
    );

    localparam longint MAXM = 64'h7FFF_FFFF;

    // behavioural reference state
    logic [31:0] m_acc, m_opb, p_acc;
    bit m_busy, m_done, m_ovf, m_dz, p_ovf, p_dz;
    int m_left;

    function automatic void ref_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output bit ov, output bit dz, output int lat);
        longint ma = longint'(a[30:0]);
        longint mb = longint'(b[30:0]);
        longint m;
        bit s, sbe;
        ov = 0; dz = 0;
        if (o == 2'b11 && mb == 0) begin
            r = {a[31], 31'h7FFF_FFFF}; dz = 1; lat = 1;
            return;
        end
        case (o)
            2'b00, 2'b01: begin
                sbe = b[31] ^ (o == 2'b01);
                if (a[31] == sbe) begin m = ma + mb; s = a[31]; end
                else if (ma >= mb) begin m = ma - mb; s = a[31]; end
                else begin m = mb - ma; s = sbe; end
                lat = 1;
            end
            2'b10: begin m = (ma * mb) >>> 16; s = a[31] ^ b[31]; lat = 31; end
            default: begin m = (ma <<< 16) / mb; s = a[31] ^ b[31]; lat = 94; end
        endcase
        if (m > MAXM) begin m = MAXM; ov = 1; end
        if (m == 0) s = 0;
        r = {s, m[30:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_acc = '0; m_opb = '0; m_busy = 0; m_done = 0; m_ovf = 0; m_dz = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_acc = p_acc; m_ovf = p_ovf; m_dz = p_dz; m_done = 1; m_busy = 0;
                end
            end else if (start) begin
                ref_op(op, m_acc, m_opb, p_acc, p_ovf, p_dz, m_left);
                m_busy = 1;
            end else if (ld_en) begin
                if (ld_sel) m_opb = ld_data; else m_acc = ld_data;
            end
        end
    end

    task automatic fail_line(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (acc_o  !== m_acc)  fail_line("R3/R4/R5", "acc", acc_o, m_acc);
            if (opb_o  !== m_opb)  fail_line("R10", "opb", opb_o, m_opb);
            if (busy_o !== m_busy) fail_line("R9", "busy", 32'(busy_o), 32'(m_busy));
            if (done_o !== m_done) fail_line("R9", "done", 32'(done_o), 32'(m_done));
            if (ovf_o  !== m_ovf)  fail_line("R6", "ovf", 32'(ovf_o), 32'(m_ovf));
            if (dz_o   !== m_dz)   fail_line("R7", "dz", 32'(dz_o), 32'(m_dz));
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) fail_line(tag, what, got, exp);
    endtask

    task automatic load(input bit sel, input logic [31:0] v);
        @(posedge clk); #1;
        ld_en = 1; ld_sel = sel; ld_data = v;
        @(posedge clk); #1;
        ld_en = 0;
    endtask

    task automatic run_op(input logic [1:0] o, input string tag, input logic [31:0] exp_acc,
                          input bit exp_ovf, input bit exp_dz, input int lat);
        int k = 0;
        @(posedge clk); #1;
        start = 1; op = o;
        @(posedge clk); #1;
        start = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!done_o && k < 200);
        check(tag, "latency", 32'(k), 32'(lat + 1));
        check(tag, "result", acc_o, exp_acc);
        check("R6", "ovf", 32'(ovf_o), 32'(exp_ovf));
        check("R7", "dz", 32'(dz_o), 32'(exp_dz));
    endtask

    task automatic pair(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input string tag,
                        input logic [31:0] e, input bit eo, input bit ed, input int lat);
        load(0, a);
        load(1, b);
        run_op(o, tag, e, eo, ed, lat);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "acc", acc_o, 32'h0);
        check("R1", "opb", opb_o, 32'h0);
        check("R1", "flags", {28'h0, busy_o, done_o, ovf_o, dz_o}, 32'h0);
        rst_n = 1;

        // R2 loads
        load(0, 32'h8001_2345);
        load(1, 32'h0006_7000);
        @(negedge clk);
        check("R2", "acc load", acc_o, 32'h8001_2345);
        check("R2", "opb load", opb_o, 32'h0006_7000);

        // R3 add/sub
        pair(2'b00, 32'h0001_8000, 32'h0002_4000, "R3", 32'h0003_C000, 0, 0, 1);
        pair(2'b00, 32'h0001_8000, 32'h8002_4000, "R3", 32'h8000_C000, 0, 0, 1);
        pair(2'b01, 32'h0001_8000, 32'h8002_4000, "R3", 32'h0003_C000, 0, 0, 1);
        // R8 subtraction to zero gives positive zero
        pair(2'b01, 32'h8001_0000, 32'h8001_0000, "R8", 32'h0000_0000, 0, 0, 1);
        // R6 add overflow
        pair(2'b00, 32'h7FFF_FFFF, 32'h0000_0001, "R6", 32'h7FFF_FFFF, 1, 0, 1);

        // R4 multiply
        pair(2'b10, 32'h0001_8000, 32'h8002_4000, "R4", 32'h8003_6000, 0, 0, 31);
        pair(2'b10, 32'hC000_0000, 32'h0002_0000, "R6", 32'hFFFF_FFFF, 1, 0, 31);
        pair(2'b10, 32'h8000_0001, 32'h0000_8000, "R8", 32'h0000_0000, 0, 0, 31);

        // R5 divide
        pair(2'b11, 32'h0007_0000, 32'h0002_0000, "R5", 32'h0003_8000, 0, 0, 94);
        pair(2'b11, 32'h8007_0000, 32'h0002_0000, "R5", 32'h8003_8000, 0, 0, 94);
        pair(2'b11, 32'h0001_0000, 32'h8003_0000, "R5", 32'h8000_5555, 0, 0, 94);
        pair(2'b11, 32'h0010_0000, 32'h0000_0001, "R6", 32'h7FFF_FFFF, 1, 0, 94);
        // R7 divide by zero
        pair(2'b11, 32'h8005_0000, 32'h8000_0000, "R7", 32'hFFFF_FFFF, 0, 1, 1);
        // R7 dz cleared by next completion
        pair(2'b00, 32'h0000_0001, 32'h0000_0001, "R7", 32'h0000_0002, 0, 0, 1);

        // R9/R10: loads and starts ignored while busy
        load(0, 32'h0002_0000);
        load(1, 32'h0003_0000);
        @(posedge clk); #1;
        start = 1; op = 2'b10;
        @(posedge clk); #1;
        op = 2'b00; ld_en = 1; ld_sel = 1; ld_data = 32'h1234_5678;
        repeat (5) @(posedge clk);
        #1;
        ld_sel = 0;
        repeat (3) @(posedge clk);
        #1;
        start = 0; ld_en = 0;
        while (!done_o) @(negedge clk);
        check("R9", "mul result after busy starts", acc_o, 32'h0006_0000);
        check("R10", "opb kept", opb_o, 32'h0003_0000);
        @(negedge clk);
        check("R9", "done pulse width", 32'(done_o), 32'h0);

        // R10: load together with start is ignored
        @(posedge clk); #1;
        start = 1; op = 2'b00; ld_en = 1; ld_sel = 0; ld_data = 32'h0FFF_0000;
        @(posedge clk); #1;
        start = 0; ld_en = 0;
        @(negedge clk); @(negedge clk);
        check("R10", "load with start", acc_o, 32'h0009_0000);

        // random mix checked by the cycle model
        for (int i = 0; i < 48; i++) begin
            logic [31:0] a, b;
            int sh;
            sh = i % 4;
            a = $urandom;
            b = $urandom;
            a[30:0] = a[30:0] >> (sh * 6);
            b[30:0] = b[30:0] >> ((3 - sh) * 6 + 2);
            if (i % 11 == 5) b[30:0] = '0;
            load(0, a);
            load(1, b);
            @(posedge clk); #1;
            start = 1; op = 2'(i);
            @(posedge clk); #1;
            start = 0;
            while (!done_o) @(negedge clk);
        end

        repeat (3) @(posedge clk);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired got %0d cycles expected fewer", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule